// File: doc/BRIEF.md
# Peripheral register write-protection controller

This block sits between a simple register bus and a group of protected peripheral registers. It decides, for every write, whether the strobe may reach the peripheral. Each protected target is tied to one control pair. The pair holds a write-enable bit and a lock bit that can only be set. A write gets through only when the pair is enabled and unlocked. Reads are never held back.

Targets come from a map fixed at elaboration. Each map entry covers either one address or an inclusive address range, and names the control pair that governs it. Several entries may share a pair. Software programs the pairs through three control words that are themselves always writable.

A change to the protection state reaches the write gate through a two-stage permission pipeline. A dropped write raises a one-cycle pulse and sets a sticky status bit. Software clears the sticky bit by writing 1 to it.

Top module: `periph_write_guard`

## Requirements
- R1: A write to a mapped address reaches `per_wr_o` only when its pair has write-enable 1 and lock 0. Otherwise the write is dropped.
- R2: For any non-control address, `per_rd_o` equals `rd_en_i`, whatever the protection state.
- R3: After reset, every write-enable bit is 1, every lock bit is 0 and the status bit is 0, so every mapped write passes.
- R4: Writing to the lock word (0xF00+1) ORs data bits [N_PAIR-1:0] into the lock bits. A 0 never clears a lock bit. Only reset clears it.
- R5: After a control write in cycle n, target writes in cycles n+1 and n+2 use the old permission. From cycle n+3 they use the new permission.
- R6: A range entry protects every address from its base to its end inclusive. The addresses just outside the range are not covered by that entry.
- R7: A write to an address outside every map entry always passes.
- R8: The control words are write-enable at 0xF00, lock at 0xF01 and status at 0xF02 (bit 0).
  - They are never write-protected.
  - They are never forwarded on `per_wr_o` or `per_rd_o`.
  - While `rd_en_i` addresses a control word, `ctrl_rdata_o` returns it zero-extended in the same cycle. Otherwise `ctrl_rdata_o` is 0.
- R9: A dropped write sets `viol_pulse_o` for exactly the next cycle and sets `viol_sticky_o`. Writing 1 to status bit 0 clears the sticky bit. Writing 0 to it has no effect.
- R10: `per_wr_o` is combinational from `wr_en_i` and `addr_i`, and is valid in the same cycle as the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | DATA_W | Bus write data |
| per_wr_o | output | 1 | Gated write strobe to the peripherals |
| per_rd_o | output | 1 | Read strobe to the peripherals |
| ctrl_rdata_o | output | DATA_W | Control word read data |
| viol_pulse_o | output | 1 | One-cycle dropped-write pulse |
| viol_sticky_o | output | 1 | Sticky dropped-write status |

## Verification
The results are due at three different times:
- `per_wr_o`, `per_rd_o` and `ctrl_rdata_o` are due in the same cycle as the request.
- `viol_pulse_o` and `viol_sticky_o` are due one cycle after the dropped write.
- A control write changes the gate decision only from the third cycle after it.

The bench drives inputs on the falling edge and samples one nanosecond later. At each rising edge it advances a reference model that keeps its own two-deep history of permissions. Every comparison therefore lines up with the cycle in which the design's registered state has moved.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    CSR_NONE,
    CSR_WE,
    CSR_LK,
    CSR_STAT
  } csr_sel_e;
endpackage

// File: rtl/pwg_ctrl_regs.sv
module pwg_ctrl_regs
  import pwg_pkg::*;
#(
  parameter int unsigned N_PAIR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  csr_sel_e          sel_i,
  input  logic [N_PAIR-1:0] wdata_i,
  input  logic              stat_clr_i,
  input  logic              drop_i,
  output logic [N_PAIR-1:0] we_o,
  output logic [N_PAIR-1:0] lk_o,
  output logic              stat_o,
  output logic              pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= '1;
      lk_o    <= '0;
      stat_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      if (wr_i && sel_i == CSR_WE) we_o <= wdata_i;
      if (wr_i && sel_i == CSR_LK) lk_o <= lk_o | wdata_i;  // set-only
      if (drop_i) stat_o <= 1'b1;
      else if (wr_i && sel_i == CSR_STAT && stat_clr_i) stat_o <= 1'b0;
      pulse_o <= drop_i;
    end
  end

  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lk_o & $past(lk_o)) == $past(lk_o)));

  // R9
  pulse_follows_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> (pulse_o && stat_o));
endmodule

// File: rtl/pwg_addr_decode.sv
module pwg_addr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned N_PAIR   = 4,
  parameter int unsigned N_ENT    = 6,
  parameter int unsigned ENT_BASE [N_ENT] = '{default: 0},
  parameter int unsigned ENT_END  [N_ENT] = '{default: 0},
  parameter int unsigned ENT_PAIR [N_ENT] = '{default: 0}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_PAIR-1:0] hit_o
);
  logic [N_ENT-1:0] ent_hit;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    assign ent_hit[e] = (addr_i >= ADDR_W'(ENT_BASE[e])) &&
                        (addr_i <= ADDR_W'(ENT_END[e]));
  end

  always_comb begin
    hit_o = '0;
    for (int e = 0; e < N_ENT; e++) begin
      for (int p = 0; p < N_PAIR; p++) begin
        if (ENT_PAIR[e] == p && ent_hit[e]) hit_o[p] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwg_perm_pipe.sv
module pwg_perm_pipe #(
  parameter int unsigned N_PAIR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PAIR-1:0] eff_i,
  output logic [N_PAIR-1:0] perm_o
);
  logic [N_PAIR-1:0] stage1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '1;
      perm_o   <= '1;
    end else begin
      stage1_q <= eff_i;
      perm_o   <= stage1_q;
    end
  end

  // R5
  perm_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##2 (perm_o == $past(eff_i, 2)));
endmodule

// File: rtl/periph_write_guard.sv
module periph_write_guard
  import pwg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned N_PAIR    = 4,
  parameter int unsigned N_ENT     = 6,
  parameter int unsigned ENT_BASE [N_ENT] = '{32'h010, 32'h020, 32'h030, 32'h031, 32'h040, 32'h048},
  parameter int unsigned ENT_END  [N_ENT] = '{32'h010, 32'h02F, 32'h030, 32'h037, 32'h040, 32'h04B},
  parameter int unsigned ENT_PAIR [N_ENT] = '{0, 1, 2, 2, 3, 3},
  parameter int unsigned WE_ADDR   = 32'hF00,
  parameter int unsigned LK_ADDR   = 32'hF01,
  parameter int unsigned STAT_ADDR = 32'hF02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              per_wr_o,
  output logic              per_rd_o,
  output logic [DATA_W-1:0] ctrl_rdata_o,
  output logic              viol_pulse_o,
  output logic              viol_sticky_o
);
  csr_sel_e          sel;
  logic              is_ctrl;
  logic [N_PAIR-1:0] we_q, lk_q, perm, hit;
  logic              allowed, drop;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:N_PAIR];

  always_comb begin
    sel = CSR_NONE;
    if (addr_i == ADDR_W'(WE_ADDR))        sel = CSR_WE;
    else if (addr_i == ADDR_W'(LK_ADDR))   sel = CSR_LK;
    else if (addr_i == ADDR_W'(STAT_ADDR)) sel = CSR_STAT;
  end
  assign is_ctrl = (sel != CSR_NONE);

  pwg_addr_decode #(
    .ADDR_W(ADDR_W), .N_PAIR(N_PAIR), .N_ENT(N_ENT),
    .ENT_BASE(ENT_BASE), .ENT_END(ENT_END), .ENT_PAIR(ENT_PAIR)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  pwg_perm_pipe #(.N_PAIR(N_PAIR)) u_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .eff_i (we_q & ~lk_q),
    .perm_o(perm)
  );

  // every pair covering the address must permit the write
  assign allowed  = ~|(hit & ~perm);
  assign drop     = wr_en_i & ~is_ctrl & ~allowed;
  assign per_wr_o = wr_en_i & ~is_ctrl & allowed;
  assign per_rd_o = rd_en_i & ~is_ctrl;

  pwg_ctrl_regs #(.N_PAIR(N_PAIR)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_en_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i[N_PAIR-1:0]),
    .stat_clr_i(wdata_i[0]),
    .drop_i    (drop),
    .we_o      (we_q),
    .lk_o      (lk_q),
    .stat_o    (viol_sticky_o),
    .pulse_o   (viol_pulse_o)
  );

  always_comb begin
    ctrl_rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel)
        CSR_WE:   ctrl_rdata_o = DATA_W'(we_q);
        CSR_LK:   ctrl_rdata_o = DATA_W'(lk_q);
        CSR_STAT: ctrl_rdata_o = DATA_W'(viol_sticky_o);
        default:  ctrl_rdata_o = '0;
      endcase
    end
  end

  // R1
  locked_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##2 ((wr_en_i && !is_ctrl && ((hit & ($past(lk_q, 2) | ~$past(we_q, 2))) != '0))
      |-> !per_wr_o));

  // R2
  read_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_ctrl) |-> per_rd_o);

  // R8
  ctrl_not_forwarded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ctrl |-> (!per_wr_o && !per_rd_o));

  // R9
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_pulse_o && !$past(drop)) |-> 1'b0);
endmodule

// File: tb/tb_periph_write_guard.sv
`timescale 1ns/1ps
module tb_periph_write_guard;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        per_wr_o, per_rd_o, viol_pulse_o, viol_sticky_o;
  logic [15:0] ctrl_rdata_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [NP-1:0] we_m, lk_m, p1_m, p2_m;
  logic          pulse_m, sticky_m;

  always #2.5 clk = ~clk;

  periph_write_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .per_wr_o(per_wr_o), .per_rd_o(per_rd_o),
    .ctrl_rdata_o(ctrl_rdata_o), .viol_pulse_o(viol_pulse_o), .viol_sticky_o(viol_sticky_o)
  );

  function automatic logic [NP-1:0] pairs_of(input logic [11:0] a);
    logic [NP-1:0] m = '0;
    if (a == 12'h010) m[0] = 1'b1;
    if (a >= 12'h020 && a <= 12'h02F) m[1] = 1'b1;
    if (a >= 12'h030 && a <= 12'h037) m[2] = 1'b1;
    if (a == 12'h040 || (a >= 12'h048 && a <= 12'h04B)) m[3] = 1'b1;
    return m;
  endfunction

  function automatic bit is_ctrl(input logic [11:0] a);
    return a == 12'hF00 || a == 12'hF01 || a == 12'hF02;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    we_m = '1; lk_m = '0; p1_m = '1; p2_m = '1; pulse_m = 0; sticky_m = 0;
  endtask

  task automatic cycle(input bit wr, input bit rd, input logic [11:0] a,
                       input logic [15:0] d, input string tag);
    logic exp_wr, drop;
    logic [15:0] exp_rd;
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
    #1;
    drop   = wr && !is_ctrl(a) && ((pairs_of(a) & ~p2_m) != '0);
    exp_wr = wr && !is_ctrl(a) && !drop;  // R10 same-cycle strobe
    exp_rd = '0;
    if (rd && a == 12'hF00) exp_rd = 16'(we_m);
    if (rd && a == 12'hF01) exp_rd = 16'(lk_m);
    if (rd && a == 12'hF02) exp_rd = 16'(sticky_m);
    chk(tag, "per_wr", 16'(per_wr_o), 16'(exp_wr));
    chk(is_ctrl(a) ? "R8" : "R2", "per_rd", 16'(per_rd_o), 16'(rd && !is_ctrl(a)));
    chk("R8", "ctrl_rdata", ctrl_rdata_o, exp_rd);
    chk("R9", "viol_pulse", 16'(viol_pulse_o), 16'(pulse_m));
    chk("R9", "viol_sticky", 16'(viol_sticky_o), 16'(sticky_m));
    @(posedge clk);
    p2_m = p1_m;
    p1_m = we_m & ~lk_m;
    if (wr && a == 12'hF00) we_m = d[NP-1:0];
    if (wr && a == 12'hF01) lk_m = lk_m | d[NP-1:0];
    if (drop) sticky_m = 1;
    else if (wr && a == 12'hF02 && d[0]) sticky_m = 0;
    pulse_m = drop;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; wr_en_i = 0; rd_en_i = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] pool [16];
    pool = '{12'h010, 12'h00F, 12'h011, 12'h020, 12'h02F, 12'h01F, 12'h025, 12'h030,
             12'h033, 12'h037, 12'h038, 12'h040, 12'h048, 12'h04B, 12'h04C, 12'h100};
    void'($urandom(32'hC0FFEE));
    model_reset();
    do_reset();
    // R3 reset state
    cycle(0, 1, 12'hF00, 0, "R3");
    cycle(0, 1, 12'hF01, 0, "R3");
    cycle(0, 1, 12'hF02, 0, "R3");
    cycle(1, 0, 12'h010, 16'h1, "R3");
    cycle(1, 0, 12'h04B, 16'h1, "R3");
    // R5 delay: disable pair 1
    cycle(1, 0, 12'hF00, 16'hD, "R8");
    cycle(1, 0, 12'h025, 0, "R5");
    cycle(1, 0, 12'h025, 0, "R5");
    cycle(1, 0, 12'h025, 0, "R5");
    // R6 range bounds
    cycle(1, 0, 12'h020, 0, "R6");
    cycle(1, 0, 12'h02F, 0, "R6");
    cycle(1, 0, 12'h01F, 0, "R6");
    cycle(1, 0, 12'h030, 0, "R6");
    cycle(1, 0, 12'h100, 0, "R7");
    cycle(0, 1, 12'h025, 0, "R2");
    // R9 clear with 0 then 1
    cycle(1, 0, 12'hF02, 16'h0, "R9");
    cycle(0, 1, 12'hF02, 0, "R9");
    cycle(1, 0, 12'hF02, 16'h1, "R9");
    cycle(0, 1, 12'hF02, 0, "R9");
    // R4 lock pair 2, re-enable all
    cycle(1, 0, 12'hF01, 16'h4, "R4");
    cycle(1, 0, 12'hF00, 16'hF, "R4");
    cycle(0, 0, 12'h000, 0, "R4");
    cycle(0, 0, 12'h000, 0, "R4");
    cycle(1, 0, 12'h033, 0, "R4");
    cycle(1, 0, 12'h030, 0, "R4");
    cycle(1, 0, 12'h038, 0, "R6");
    cycle(1, 0, 12'h025, 0, "R1");
    cycle(1, 0, 12'hF01, 16'h0, "R4");
    cycle(0, 1, 12'hF01, 0, "R4");
    cycle(1, 0, 12'h037, 0, "R4");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [11:0] a = pool[$urandom_range(0, 15)];
      logic [15:0] d = 16'($urandom);
      if (r < 8) a = 12'hF00;
      else if (r < 9) begin a = 12'hF01; d = 16'(1 << $urandom_range(0, NP - 1)); end
      else if (r < 12) a = 12'hF02;
      if (i == 2000) do_reset();
      cycle(r[0] | (r < 12), $urandom_range(0, 1) == 1, a, d, "R1");
    end
    do_reset();
    cycle(0, 1, 12'hF01, 0, "R3");
    cycle(1, 0, 12'h033, 0, "R3");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule